// File: doc/BRIEF.md
# Second-Level I/O Page-Table Walker

This block translates a DMA I/O virtual address into a physical page by walking a radix tree of 64-bit paging entries held in memory. A requester hands it the address, whether the access is a read or a write, the physical address of the top table, the number of paging levels (3, 4 or 5), a 2-bit large-page capability mask and a flag that selects the legacy or the scalable fault-code set. The walker then issues one memory read per level and examines each returned entry. The walk ends at a leaf, which is either a level-0 entry or an accepted 2 MiB or 1 GiB large-page entry.

When the walk ends, the block returns either the translated page base, the page-size shift and the AND of the read and write permissions it met along the path, or a single 4-bit fault code. Fault classification follows a fixed priority inside each entry. A read error comes first, then the permission check, then the reserved-bit check, then the large-page capability check. A read error is reported as a root-table fault when the table being read is the root table, and as an entry-read fault otherwise.

Top module: `slpt_walker`

## Requirements
- R1: After a synchronous active-low reset the block is idle: req_ready is 1, and done, xlat_valid, fault_valid and mem_rd_valid are 0.
- R2: A walk with req_levels = N starts at level N-1 and issues exactly one read per level, stepping down by one, until it reaches a leaf. A 4 KiB mapping therefore costs exactly N reads, with no level skipped.
- R3: The read address at level L is {table frame, iova[12+9L +: 9], 3'b000}. The first table frame is req_root[PA_W-1:12], and each later frame is bits [PA_W-1:12] of the previous entry.
- R4: A level-0 entry ends the walk with xlat_base = entry[PA_W-1:12] followed by twelve zero bits, and xlat_shift = 12. xlat_perm is the AND of entry bits [1:0] over every entry of the walk, where bit 0 grants read and bit 1 grants write.
- R5: When the permission bit needed by the access (bit 0 for a read, bit 1 for a write) is clear in any entry, the walk stops at that entry with the permission condition (3). No further read is issued.
- R6: Bits [63:52] are reserved at every level. Bit 7 is also reserved at levels 3 and 4. Any set reserved bit raises condition 4, but a permission failure in the same entry takes precedence and reports condition 3.
- R7: Bit 7 at level 1 or level 2 marks a large page. It is accepted only when cap_large[level-1] is 1, and then it ends the walk with the base cleared below bit 21 or bit 30 and xlat_shift = 21 or 30. If the capability bit is 0, the walk raises condition 5. Bit 7 at level 0 is ignored.
- R8: A failed read (mem_rsp_err = 1) stops the walk. The condition is 1 when the table being read has the same frame as the root table, and 2 otherwise. This includes a deeper entry that points back to the root table.
- R9: fault_code = {req_scalable, condition[2:0]}. The legacy codes are therefore 1..5 and the scalable codes are 9..13.
- R10: A request is taken only while req_ready is 1, which holds only when the block is idle. req_valid during a walk has no effect. done is a one-cycle pulse, and exactly one of xlat_valid and fault_valid is high with it.
- R11: A read request keeps mem_rd_valid high and mem_rd_addr stable until it is accepted with mem_rd_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_iova | input | IOVA_W | I/O virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_scalable | input | 1 | Selects the scalable fault-code set |
| req_root | input | PA_W | Physical address of the top table |
| req_levels | input | 3 | Number of paging levels (3, 4 or 5) |
| cap_large | input | 2 | Bit 0 allows 2 MiB pages, bit 1 allows 1 GiB pages |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Returned paging entry |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle walk completion pulse |
| xlat_valid | output | 1 | Walk ended in a translation |
| xlat_base | output | PA_W | Translated page base |
| xlat_shift | output | 6 | Page-size shift (12, 21 or 30) |
| xlat_perm | output | 2 | Accumulated {write, read} permission |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_code | output | 4 | {scalable, condition} |

## Verification
The hardest case to reach from the ports is a read error on an entry below the top level whose table frame equals the root frame. A normally built tree never points back at its root, so the bench builds a tree whose top entry names the root table itself and leaves the second indexed slot unmapped. This produces the root-read fault at depth two. Ordering faults within one entry is equally hard to reach: the bench writes entries that break the permission and the reserved-bit rules at the same time, and sets large-page bits against each capability mask. Together these show which condition wins.

// File: rtl/slw_pkg.sv
// Package: shared constants and types for the second-level page-table walker.
// Assumes 64-bit paging entries and 4 KiB tables of 512 entries.
package slw_pkg;

    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned IDX_BITS   = 9;
    localparam int unsigned ENTRY_W    = 64;
    localparam int unsigned BIT_RD     = 0;
    localparam int unsigned BIT_WR     = 1;
    localparam int unsigned BIT_PS     = 7;
    localparam int unsigned RSVD_LO    = 52;
    localparam int unsigned LEAF_LVLS  = 3;

    // Fault condition carried in the low three bits of the fault code.
    typedef enum logic [2:0] {
        COND_NONE     = 3'd0,
        COND_ROOT_RD  = 3'd1,
        COND_ENTRY_RD = 3'd2,
        COND_PERM     = 3'd3,
        COND_RSVD     = 3'd4,
        COND_LARGE    = 3'd5
    } walk_cond_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/slw_addr_gen.sv
// Module: slw_addr_gen
// Forms the byte address of the paging entry for the current level.
// The 9-bit index is taken from the address field selected by the level.
// Assumes the index field input covers IDX_BITS*MAX_LEVELS bits above the
// page offset. A level outside 0..MAX_LEVELS-1 yields index 0.
module slw_addr_gen
    import slw_pkg::*;
#(
    parameter int unsigned PA_W       = 52,
    parameter int unsigned MAX_LEVELS = 5,
    parameter int unsigned LVL_W      = 3
) (
    input  logic [IDX_BITS*MAX_LEVELS-1:0] idx_field,
    input  logic [PA_W-PAGE_SHIFT-1:0]     table_frame,
    input  logic [LVL_W-1:0]               level,
    output logic [PA_W-1:0]                entry_addr
);

    logic [IDX_BITS-1:0] idx_at [MAX_LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    // One index slice per level.
    for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_idx
        assign idx_at[l] = idx_field[IDX_BITS*l +: IDX_BITS];
    end

    // Pick the slice of the current level.
    always_comb begin : p_idx_sel
        idx_sel = '0;
        for (int l = 0; l < MAX_LEVELS; l++) begin
            if (level == LVL_W'(l)) idx_sel = idx_at[l];
        end
    end

    // The table frame is 4 KiB aligned and each entry is 8 bytes.
    assign entry_addr = {table_frame, idx_sel, 3'b000};

endmodule

// File: rtl/slw_entry_check.sv
// Module: slw_entry_check
// Classifies one returned paging entry. It computes the permission result,
// the per-level reserved-bit result, the large-page legality, whether the
// entry is a leaf, and the leaf base and shift.
// Assumes PA_W > PAGE_SHIFT + 2*IDX_BITS so that a 1 GiB base fits.
module slw_entry_check
    import slw_pkg::*;
#(
    parameter int unsigned PA_W       = 52,
    parameter int unsigned MAX_LEVELS = 5,
    parameter int unsigned LVL_W      = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic               is_write,
    input  logic [1:0]         cap_large,
    output logic               perm_ok,
    output logic               rsvd_ok,
    output logic               large_bad,
    output logic               is_leaf,
    output logic [PA_W-1:0]    leaf_base,
    output logic [5:0]         leaf_shift
);

    localparam logic [ENTRY_W-1:0] RSVD_HIGH = {ENTRY_W{1'b1}} << RSVD_LO;
    localparam logic [ENTRY_W-1:0] PS_MASK   = ENTRY_W'(1) << BIT_PS;

    logic [ENTRY_W-1:0] rsvd_mask [MAX_LEVELS];
    logic [PA_W-1:0]    base_at   [LEAF_LVLS];
    logic [ENTRY_W-1:0] mask_sel;
    logic               large_req;
    logic               cap_ok;

    // Reserved mask per level; the upper levels also reserve the page-size bit.
    for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_rsvd
        if (l >= LEAF_LVLS) begin : g_upper
            assign rsvd_mask[l] = RSVD_HIGH | PS_MASK;
        end else begin : g_lower
            assign rsvd_mask[l] = RSVD_HIGH;
        end
    end

    // Leaf base per level, with the bits below the page shift cleared.
    for (genvar l = 0; l < LEAF_LVLS; l++) begin : g_base
        assign base_at[l] = {entry[PA_W-1:PAGE_SHIFT+IDX_BITS*l],
                             {(PAGE_SHIFT+IDX_BITS*l){1'b0}}};
    end

    // Select the reserved mask of the current level.
    always_comb begin : p_mask_sel
        mask_sel = rsvd_mask[0];
        for (int l = 0; l < MAX_LEVELS; l++) begin
            if (level == LVL_W'(l)) mask_sel = rsvd_mask[l];
        end
    end

    // Permission, reserved and large-page decisions for this entry.
    always_comb begin : p_classify
        perm_ok   = is_write ? entry[BIT_WR] : entry[BIT_RD];
        rsvd_ok   = ((entry & mask_sel) == '0);
        large_req = entry[BIT_PS] && ((level == LVL_W'(1)) || (level == LVL_W'(2)));
        cap_ok    = (level == LVL_W'(1)) ? cap_large[0] : cap_large[1];
        large_bad = large_req && !cap_ok;
        is_leaf   = (level == '0) || (large_req && cap_ok);
    end

    // Base and shift of a leaf at this level.
    always_comb begin : p_leaf
        leaf_base  = base_at[0];
        leaf_shift = 6'(PAGE_SHIFT);
        for (int l = 1; l < LEAF_LVLS; l++) begin
            if (level == LVL_W'(l)) begin
                leaf_base  = base_at[l];
                leaf_shift = 6'(PAGE_SHIFT + IDX_BITS*l);
            end
        end
    end

endmodule

// File: rtl/slpt_walker.sv
// Module: slpt_walker (top)
// Walks a multi-level table of 64-bit entries for one DMA address at a time.
// The flow is: accept a request while idle, issue one entry read per level
// with a valid/ready handshake, wait for the response, then classify the
// entry. Classification either ends the walk (leaf or fault) or descends
// one level. Completion is a one-cycle done pulse.
// Assumes req_levels is 3, 4 or 5 and that responses arrive in order,
// one per accepted read.
module slpt_walker
    import slw_pkg::*;
#(
    parameter int unsigned IOVA_W     = 64,
    parameter int unsigned PA_W       = 52,
    parameter int unsigned MAX_LEVELS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOVA_W-1:0] req_iova,
    input  logic              req_write,
    input  logic              req_scalable,
    input  logic [PA_W-1:0]   req_root,
    input  logic [2:0]        req_levels,
    input  logic [1:0]        cap_large,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic              xlat_valid,
    output logic [PA_W-1:0]   xlat_base,
    output logic [5:0]        xlat_shift,
    output logic [1:0]        xlat_perm,
    output logic              fault_valid,
    output logic [3:0]        fault_code
);

    localparam int unsigned LVL_W   = 3;
    localparam int unsigned IDX_W   = IDX_BITS * MAX_LEVELS;
    localparam int unsigned IDX_TOP = PAGE_SHIFT + IDX_W;
    localparam int unsigned FRAME_W = PA_W - PAGE_SHIFT;

    walk_state_e         state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [FRAME_W-1:0]  frame_q;
    logic [FRAME_W-1:0]  root_q;
    logic [LVL_W-1:0]    level_q;
    logic                write_q;
    logic                scal_q;
    logic [1:0]          cap_q;
    logic [1:0]          perm_q;
    logic                fault_q;
    walk_cond_e          cond_q;
    logic [PA_W-1:0]     base_q;
    logic [5:0]          shift_q;
    logic [1:0]          perm_out_q;

    logic                perm_ok;
    logic                rsvd_ok;
    logic                large_bad;
    logic                is_leaf;
    logic [PA_W-1:0]     leaf_base;
    logic [5:0]          leaf_shift;
    walk_cond_e          step_cond;
    logic                root_hit;
    logic                unused_iova;
    logic                unused_root;

    // Address bits outside the index fields and the root page offset are not needed.
    assign unused_iova = ^req_iova[PAGE_SHIFT-1:0] ^ ^(req_iova >> IDX_TOP);
    assign unused_root = ^req_root[PAGE_SHIFT-1:0];

    slw_addr_gen #(
        .PA_W       (PA_W),
        .MAX_LEVELS (MAX_LEVELS),
        .LVL_W      (LVL_W)
    ) u_addr (
        .idx_field   (idx_q),
        .table_frame (frame_q),
        .level       (level_q),
        .entry_addr  (mem_rd_addr)
    );

    slw_entry_check #(
        .PA_W       (PA_W),
        .MAX_LEVELS (MAX_LEVELS),
        .LVL_W      (LVL_W)
    ) u_check (
        .entry      (mem_rsp_data),
        .level      (level_q),
        .is_write   (write_q),
        .cap_large  (cap_q),
        .perm_ok    (perm_ok),
        .rsvd_ok    (rsvd_ok),
        .large_bad  (large_bad),
        .is_leaf    (is_leaf),
        .leaf_base  (leaf_base),
        .leaf_shift (leaf_shift)
    );

    // A read error is a root fault when the table read is the root table.
    assign root_hit = (frame_q == root_q);

    // Fault priority within one entry: read error, permission, reserved, large page.
    always_comb begin : p_step_cond
        step_cond = COND_NONE;
        if (mem_rsp_err)   step_cond = root_hit ? COND_ROOT_RD : COND_ENTRY_RD;
        else if (!perm_ok) step_cond = COND_PERM;
        else if (!rsvd_ok) step_cond = COND_RSVD;
        else if (large_bad) step_cond = COND_LARGE;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin : p_walk
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            frame_q    <= '0;
            root_q     <= '0;
            level_q    <= '0;
            write_q    <= 1'b0;
            scal_q     <= 1'b0;
            cap_q      <= '0;
            perm_q     <= '0;
            fault_q    <= 1'b0;
            cond_q     <= COND_NONE;
            base_q     <= '0;
            shift_q    <= '0;
            perm_out_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= req_iova[IDX_TOP-1:PAGE_SHIFT];
                        frame_q <= req_root[PA_W-1:PAGE_SHIFT];
                        root_q  <= req_root[PA_W-1:PAGE_SHIFT];
                        level_q <= req_levels - 3'd1;
                        write_q <= req_write;
                        scal_q  <= req_scalable;
                        cap_q   <= cap_large;
                        perm_q  <= 2'b11;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (step_cond != COND_NONE) begin
                            fault_q <= 1'b1;
                            cond_q  <= step_cond;
                            state_q <= ST_DONE;
                        end else if (is_leaf) begin
                            fault_q    <= 1'b0;
                            cond_q     <= COND_NONE;
                            base_q     <= leaf_base;
                            shift_q    <= leaf_shift;
                            perm_out_q <= perm_q & mem_rsp_data[1:0];
                            state_q    <= ST_DONE;
                        end else begin
                            frame_q <= mem_rsp_data[PA_W-1:PAGE_SHIFT];
                            level_q <= level_q - 3'd1;
                            perm_q  <= perm_q & mem_rsp_data[1:0];
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port-level view of the sequencer state.
    always_comb begin : p_outputs
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_ISSUE);
        done         = (state_q == ST_DONE);
        xlat_valid   = done && !fault_q;
        fault_valid  = done && fault_q;
        fault_code   = {scal_q, cond_q};
        xlat_base    = base_q;
        xlat_shift   = shift_q;
        xlat_perm    = perm_out_q;
    end

endmodule

// File: rtl/slpt_walker_chk.sv
// Module: slpt_walker_chk
// Protocol and result checks for slpt_walker, attached with bind.
module slpt_walker_chk #(
    parameter int unsigned PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            done,
    input logic            xlat_valid,
    input logic [PA_W-1:0] xlat_base,
    input logic [5:0]      xlat_shift,
    input logic            fault_valid,
    input logic [3:0]      fault_code
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_rd_valid && req_ready));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xlat_valid != fault_valid));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || done) |-> !req_ready);

    assert_fault_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ((fault_code[2:0] >= 3'd1) && (fault_code[2:0] <= 3'd5)));

    assert_leaf_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_valid |-> ((xlat_shift == 6'd12) || (xlat_shift == 6'd21) || (xlat_shift == 6'd30)));

    assert_leaf_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_valid |-> (xlat_base[11:0] == 12'h000));

endmodule

bind slpt_walker slpt_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .done         (done),
    .xlat_valid   (xlat_valid),
    .xlat_base    (xlat_base),
    .xlat_shift   (xlat_shift),
    .fault_valid  (fault_valid),
    .fault_code   (fault_code)
);

// File: tb/tb_slpt_walker.sv
`timescale 1ns/1ps
module tb_slpt_walker;

    localparam int unsigned PA_W = 52;
    localparam logic [63:0] IA   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IB   = 64'h0000_7654_3210_F000;
    localparam logic [63:0] PAGE = 64'h0000_000A_BCDE_F000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_iova = '0;
    logic            req_write = 1'b0;
    logic            req_scalable = 1'b0;
    logic [PA_W-1:0] req_root = '0;
    logic [2:0]      req_levels = 3'd4;
    logic [1:0]      cap_large = 2'b00;
    logic            mem_rd_valid;
    logic            mem_rd_ready = 1'b1;
    logic [PA_W-1:0] mem_rd_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            done;
    logic            xlat_valid;
    logic [PA_W-1:0] xlat_base;
    logic [5:0]      xlat_shift;
    logic [1:0]      xlat_perm;
    logic            fault_valid;
    logic [3:0]      fault_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [63:0] mem [bit [63:0]];
    logic [63:0] rd_log [16];
    int          rd_cnt = 0;
    int          rsp_delay = 0;
    bit          stall_mode = 0;

    logic            r_xv, r_fv;
    logic [PA_W-1:0] r_base;
    logic [5:0]      r_shift;
    logic [1:0]      r_perm;
    logic [3:0]      r_code;

    slpt_walker #(.IOVA_W(64), .PA_W(PA_W), .MAX_LEVELS(5)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_write(req_write), .req_scalable(req_scalable),
        .req_root(req_root), .req_levels(req_levels), .cap_large(cap_large),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .xlat_valid(xlat_valid), .xlat_base(xlat_base), .xlat_shift(xlat_shift),
        .xlat_perm(xlat_perm), .fault_valid(fault_valid), .fault_code(fault_code)
    );

    always #2.5 clk = ~clk;

    // Table of level l lives at its own 1 MiB-spaced frame.
    function automatic logic [63:0] tbl(input int l);
        return 64'h0000_0001_0000_0000 + (64'(l) << 20);
    endfunction

    function automatic logic [63:0] ea(input logic [63:0] iova, input int l);
        return tbl(l) | (((iova >> (12 + 9*l)) & 64'h1FF) << 3);
    endfunction

    function automatic logic [63:0] mk(input logic [63:0] a, input bit r, input bit w);
        return (a & 64'h000F_FFFF_FFFF_F000) | {62'b0, w, r};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic build(input int lv, input logic [63:0] iova);
        mem.delete();
        for (int l = lv - 1; l >= 1; l--) mem[ea(iova, l)] = mk(tbl(l - 1), 1, 1);
        mem[ea(iova, 0)] = mk(PAGE, 1, 1);
    endtask

    // Memory model: ready pattern, then acceptance, then delayed response.
    initial begin : p_memory
        bit          pend = 0;
        int          dly = 0;
        int          cyc = 0;
        logic [63:0] paddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            mem_rd_ready  = stall_mode ? ((cyc % 3) == 0) : 1'b1;
            if (pend) begin
                if (dly > 0) dly--;
                else begin
                    pend          = 0;
                    mem_rsp_valid = 1'b1;
                    if (mem.exists(paddr)) mem_rsp_data = mem[paddr];
                    else begin
                        mem_rsp_data = '0;
                        mem_rsp_err  = 1'b1;
                    end
                end
            end else if (rst_n && mem_rd_valid && mem_rd_ready) begin
                pend  = 1;
                dly   = rsp_delay;
                paddr = 64'(mem_rd_addr);
                if (rd_cnt < 16) rd_log[rd_cnt] = paddr;
                rd_cnt++;
            end
        end
    end

    task automatic start_req(input logic [63:0] iova, input bit wr, input bit scal,
                             input int lv, input logic [1:0] cap);
        @(negedge clk);
        rd_cnt       = 0;
        req_valid    = 1'b1;
        req_iova     = iova;
        req_write    = wr;
        req_scalable = scal;
        req_levels   = 3'(lv);
        req_root     = PA_W'(tbl(lv - 1));
        cap_large    = cap;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            chk({tag, " R10 walk completes"}, 0, 1);
            return;
        end
        r_xv = xlat_valid; r_fv = fault_valid; r_base = xlat_base;
        r_shift = xlat_shift; r_perm = xlat_perm; r_code = fault_code;
        @(negedge clk);
        chk({tag, " R10 done is one cycle"}, done, 0);
    endtask

    task automatic run(input string tag, input logic [63:0] iova, input bit wr,
                       input bit scal, input int lv, input logic [1:0] cap);
        start_req(iova, wr, scal, lv, cap);
        wait_done(tag);
    endtask

    task automatic expect_fault(input string tag, input logic [3:0] code, input int reads);
        chk({tag, " fault_valid"}, r_fv, 1);
        chk({tag, " xlat_valid"}, r_xv, 0);
        chk({tag, " code"}, r_code, code);
        chk({tag, " read count"}, rd_cnt, reads);
    endtask

    task automatic t_reset;
        chk("R1 req_ready", req_ready, 1);
        chk("R1 done", done, 0);
        chk("R1 mem_rd_valid", mem_rd_valid, 0);
        chk("R1 results", {xlat_valid, fault_valid}, 0);
    endtask

    task automatic t_basic_read;
        build(4, IA);
        mem[ea(IA, 2)] = mk(tbl(1), 1, 0);
        run("basic", IA, 0, 0, 4, 2'b00);
        chk("R4 xlat_valid", r_xv, 1);
        chk("R2 four reads", rd_cnt, 4);
        for (int k = 0; k < 4; k++) chk("R3 entry address", rd_log[k], ea(IA, 3 - k));
        chk("R4 base", r_base, PA_W'(PAGE));
        chk("R4 shift", r_shift, 12);
        chk("R4 perm AND", r_perm, 2'b01);
    endtask

    task automatic t_levels;
        build(3, IB);
        run("lv3", IB, 1, 1, 3, 2'b00);
        chk("R2 three reads", rd_cnt, 3);
        for (int k = 0; k < 3; k++) chk("R3 lv3 address", rd_log[k], ea(IB, 2 - k));
        chk("R4 lv3 perm", r_perm, 2'b11);
        build(5, IA);
        stall_mode = 1; rsp_delay = 2;
        run("lv5", IA, 1, 0, 5, 2'b11);
        stall_mode = 0; rsp_delay = 0;
        chk("R2 five reads", rd_cnt, 5);
        for (int k = 0; k < 5; k++) chk("R11 R3 stalled address", rd_log[k], ea(IA, 4 - k));
        chk("R4 lv5 base", r_base, PA_W'(PAGE));
    endtask

    task automatic t_perm;
        build(4, IA);
        mem[ea(IA, 2)] = mk(tbl(1), 1, 0);
        run("perm", IA, 1, 0, 4, 2'b00);
        expect_fault("R5 write denied", 4'd3, 2);
        run("perm scal", IA, 1, 1, 4, 2'b00);
        expect_fault("R9 R5 scalable", 4'd11, 2);
    endtask

    task automatic t_rsvd;
        build(4, IA);
        mem[ea(IA, 1)] = mk(tbl(0), 0, 1) | (64'h1 << 60);
        run("both", IA, 0, 0, 4, 2'b00);
        expect_fault("R6 perm wins", 4'd3, 3);
        mem[ea(IA, 1)] = mk(tbl(0), 1, 1) | (64'h1 << 55);
        run("rsvd", IA, 0, 0, 4, 2'b00);
        expect_fault("R6 reserved", 4'd4, 3);
        build(4, IA);
        mem[ea(IA, 0)] = mk(PAGE, 1, 1) | (64'h1 << 63);
        run("rsvd0", IA, 0, 0, 4, 2'b00);
        expect_fault("R6 leaf reserved", 4'd4, 4);
        build(5, IA);
        mem[ea(IA, 3)] = mk(tbl(2), 1, 1) | 64'h80;
        run("ps3", IA, 0, 1, 5, 2'b11);
        expect_fault("R6 R9 bit7 at level 3", 4'd12, 2);
    endtask

    task automatic t_large;
        logic [63:0] e1, e2;
        e1 = 64'h0000_0040_0A3F_F083;
        e2 = 64'h0000_0040_7ABC_D083;
        build(4, IA);
        mem[ea(IA, 1)] = e1;
        run("2m", IA, 1, 0, 4, 2'b01);
        chk("R7 2M valid", r_xv, 1);
        chk("R7 2M base", r_base, PA_W'(e1 & ~((64'h1 << 21) - 1)));
        chk("R7 2M shift", r_shift, 21);
        chk("R7 2M reads", rd_cnt, 3);
        run("2m nocap", IA, 1, 0, 4, 2'b10);
        expect_fault("R7 2M not allowed", 4'd5, 3);
        build(4, IA);
        mem[ea(IA, 2)] = e2;
        run("1g", IA, 0, 0, 4, 2'b10);
        chk("R7 1G base", r_base, PA_W'(e2 & ~((64'h1 << 30) - 1)));
        chk("R7 1G shift", r_shift, 30);
        chk("R7 1G reads", rd_cnt, 2);
        run("1g nocap", IA, 0, 1, 4, 2'b01);
        expect_fault("R7 R9 1G not allowed", 4'd13, 2);
        build(4, IA);
        mem[ea(IA, 0)] = mk(PAGE, 1, 1) | 64'h80;
        run("ps0", IA, 0, 0, 4, 2'b00);
        chk("R7 bit7 at level 0 ignored", {r_xv, r_shift}, {1'b1, 6'd12});
    endtask

    task automatic t_read_err;
        build(4, IA);
        mem.delete(ea(IA, 3));
        run("root err", IA, 0, 0, 4, 2'b00);
        expect_fault("R8 root read", 4'd1, 1);
        run("root err scal", IA, 0, 1, 4, 2'b00);
        expect_fault("R9 R8 scalable root", 4'd9, 1);
        build(4, IA);
        mem.delete(ea(IA, 1));
        run("deep err", IA, 0, 0, 4, 2'b00);
        expect_fault("R8 deeper read", 4'd2, 3);
        run("deep err scal", IA, 0, 1, 4, 2'b00);
        expect_fault("R9 R8 scalable deeper", 4'd10, 3);
        mem.delete();
        mem[ea(IA, 3)] = mk(tbl(3), 1, 1);
        run("loop err", IA, 0, 0, 4, 2'b00);
        expect_fault("R8 deep entry back to root", 4'd1, 2);
    endtask

    task automatic t_busy;
        build(4, IA);
        rsp_delay = 4;
        start_req(IA, 0, 0, 4, 2'b00);
        for (int k = 0; k < 3; k++) begin
            chk("R10 not ready while busy", req_ready, 0);
            req_valid = 1'b1; req_iova = IB; req_write = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done("busy");
        rsp_delay = 0;
        chk("R10 first request result", {r_xv, r_base}, {1'b1, PA_W'(PAGE)});
        repeat (4) @(negedge clk);
        chk("R10 no extra walk", {mem_rd_valid, 8'(rd_cnt)}, {1'b0, 8'd4});
    endtask

    initial begin : p_main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_read();
        t_levels();
        t_perm();
        t_rsvd();
        t_large();
        t_read_err();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : p_watchdog
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule